// File: doc/BRIEF.md
# SMI Feature Negotiation Controller

This block lets platform firmware agree on a set of optional system-management-interrupt (SMI) features with the hardware. The hardware offers a fixed 64-bit mask of supported features, set as a parameter. Firmware loads a 64-bit request one byte at a time, least significant byte at index 0. It then pulses a trigger. The block checks the request against the supported mask and against the dependency rules between the feature bits. If the request passes, the block copies it into a negotiated mask, raises a features-ok flag and freezes both until reset. If it fails, the flag stays low and firmware may try again.

The negotiated broadcast bit then controls how SMIs are delivered. A write to the power-management command port with either of the two ACPI mode codes produces a one-cycle enable or disable strobe and nothing else. Any other command raises a one-cycle SMI pulse when the command-SMI enable input is high. The pulse goes to every CPU if broadcast was negotiated, and otherwise only to the CPU that issued the command.

The external reset is asserted asynchronously and released through a two-stage synchronizer. Internal state therefore leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `smi_feat_negotiator`

## Requirements
- R1: While in reset and after it, the request, the negotiated mask, features-ok, every SMI pulse and both ACPI strobes are zero.
- R2: A request write with byte index k (0..7) replaces bits [8k+7:8k] of the request on the next clock edge, so index 0 holds the least significant byte. Other bytes are unchanged.
- R3: While features-ok is 1, request writes are ignored and the request keeps its value.
- R4: A trigger while features-ok is 0, with a legal request, sets features-ok and loads the negotiated mask with the request on that edge. The legality check uses the request value held before any write in the same cycle.
- R5: A trigger is rejected, leaving features-ok and the negotiated mask at zero, when the request has any bit outside the host-supported mask.
- R6: A trigger is rejected when the request has CPU hotplug (bit 1) or CPU hot-unplug (bit 2) set while broadcast (bit 0) is clear.
- R7: A trigger is rejected when the request has hot-unplug (bit 2) set while hotplug (bit 1) is clear.
- R8: Once features-ok is 1, further triggers have no effect, and the negotiated mask and features-ok hold until reset.
- R9: A rejected trigger leaves the block ready for a new request and a new trigger, which can then be accepted.
- R10: A command-port write equal to the ACPI-enable code gives a one-cycle enable strobe on the next cycle. A write equal to the ACPI-disable code gives a one-cycle disable strobe. Neither raises an SMI, whatever the enable input says.
- R11: Any other command raises no SMI while the command-SMI enable input is 0.
- R12: With the enable input at 1 and broadcast negotiated (bit 0 of the negotiated mask), every bit of the SMI vector pulses on the cycle after the command write.
- R13: With the enable input at 1 and broadcast not negotiated, only the SMI bit indexed by the issuing CPU id pulses.
- R14: Each SMI pulse and each ACPI strobe lasts exactly one cycle per command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_wr_en | input | 1 | Write one byte of the feature request |
| req_wr_idx | input | 3 | Byte index of the request write, 0 = least significant |
| req_wr_data | input | 8 | Request byte value |
| ok_trigger | input | 1 | Ask the block to validate and lock the current request |
| apm_wr_en | input | 1 | Command port write |
| apm_cmd | input | 8 | Command value |
| apm_cpu_id | input | 2 | Index of the CPU issuing the command |
| apm_smi_en | input | 1 | Command-SMI enable bit |
| req_value | output | 64 | Current request contents |
| feat_ok | output | 1 | Negotiation accepted and locked |
| feat_negotiated | output | 64 | Locked negotiated feature mask |
| smi_pulse | output | 4 | Per-CPU SMI pulse |
| acpi_on_stb | output | 1 | ACPI-enable strobe |
| acpi_off_stb | output | 1 | ACPI-disable strobe |

## Verification
The bench targets the dependency rules one at a time: a request with hot-unplug but no hotplug, hotplug without broadcast, and a stray bit outside the supported mask. A design that skipped any of these checks would lock an illegal mask and raise features-ok. Triggers and request writes sent after the lock show whether a design re-validates, changes the locked mask or lets the request move. The bench also writes a byte and triggers in the same cycle, which exposes a design that validates the new value instead of the held one. On the command port it sends the two ACPI codes with the SMI enable input high, and sends ordinary commands both before and after broadcast is negotiated. A wrong design would fire an SMI on a mode change or send it to the wrong set of CPUs.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
  localparam int unsigned FEAT_W      = 64;
  localparam int unsigned BYTE_CNT    = FEAT_W / 8;
  localparam int unsigned BIDX_W      = $clog2(BYTE_CNT);
  localparam int unsigned BIT_BCAST   = 0;
  localparam int unsigned BIT_HOTADD  = 1;
  localparam int unsigned BIT_HOTDEL  = 2;

  typedef logic [FEAT_W-1:0] feat_mask_t;

  function automatic logic request_legal(input feat_mask_t req, input feat_mask_t host);
    logic extra_bits;
    logic needs_bcast;
    logic del_wo_add;
    extra_bits  = |(req & ~host);
    needs_bcast = (req[BIT_HOTADD] | req[BIT_HOTDEL]) & ~req[BIT_BCAST];
    del_wo_add  = req[BIT_HOTDEL] & ~req[BIT_HOTADD];
    return ~(extra_bits | needs_bcast | del_wo_add);
  endfunction
endpackage

// File: rtl/smi_req_file.sv
module smi_req_file
  import smi_neg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic              wr_en,
  input  logic [BIDX_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  output feat_mask_t        req_q
);
  logic [BYTE_CNT-1:0] byte_we;

  always_comb begin
    for (int b = 0; b < BYTE_CNT; b++) begin
      byte_we[b] = wr_en && !locked && (wr_idx == BIDX_W'(b));
    end
  end

  for (genvar g = 0; g < BYTE_CNT; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[8*g +: 8] <= 8'h00;
      end else if (byte_we[g]) begin
        req_q[8*g +: 8] <= wr_data;
      end
    end
  end

  // R3: no byte may move once the negotiation is locked
  a_r3_frozen_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(req_q));
endmodule

// File: rtl/smi_feat_lock.sv
module smi_feat_lock
  import smi_neg_pkg::*;
#(
  parameter feat_mask_t HOST_MASK = 64'h7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trigger,
  input  feat_mask_t req,
  output logic       feat_ok,
  output feat_mask_t neg_mask
);
  if (HOST_MASK[BIT_HOTDEL] && !HOST_MASK[BIT_HOTADD]) begin : g_bad_host_mask
    $error("host mask offers hot-unplug without hotplug");
  end

  logic accept;

  always_comb begin
    accept = trigger && !feat_ok && request_legal(req, HOST_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_ok  <= 1'b0;
      neg_mask <= '0;
    end else if (accept) begin
      feat_ok  <= 1'b1;
      neg_mask <= req;
    end
  end

  a_r4_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(feat_ok) |-> $past(trigger));
  a_r5_inside_host: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ok |-> ((neg_mask & ~HOST_MASK) == '0));
  a_r6_hotplug_needs_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_ok && (neg_mask[BIT_HOTADD] || neg_mask[BIT_HOTDEL])) |-> neg_mask[BIT_BCAST]);
  a_r7_unplug_needs_plug: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_ok && neg_mask[BIT_HOTDEL]) |-> neg_mask[BIT_HOTADD]);
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ok |=> (feat_ok && $stable(neg_mask)));
  a_r5_clear_unless_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_ok |-> (neg_mask == '0));
endmodule

// File: rtl/smi_apm_dispatch.sv
module smi_apm_dispatch #(
  parameter int unsigned NUM_CPUS      = 4,
  parameter logic [7:0]  ACPI_ON_CODE  = 8'hE1,
  parameter logic [7:0]  ACPI_OFF_CODE = 8'h1E,
  localparam int unsigned CPU_W        = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                apm_wr_en,
  input  logic [7:0]          apm_cmd,
  input  logic [CPU_W-1:0]    cpu_id,
  input  logic                smi_en,
  input  logic                bcast,
  output logic [NUM_CPUS-1:0] smi_pulse,
  output logic                acpi_on_stb,
  output logic                acpi_off_stb
);
  logic                is_on;
  logic                is_off;
  logic                fire;
  logic [NUM_CPUS-1:0] smi_d;
  logic                on_d;
  logic                off_d;

  always_comb begin
    is_on  = (apm_cmd == ACPI_ON_CODE);
    is_off = (apm_cmd == ACPI_OFF_CODE);
    on_d   = apm_wr_en && is_on;
    off_d  = apm_wr_en && is_off;
    fire   = apm_wr_en && !is_on && !is_off && smi_en;
    for (int c = 0; c < NUM_CPUS; c++) begin
      smi_d[c] = fire && (bcast || (cpu_id == CPU_W'(c)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_pulse    <= '0;
      acpi_on_stb  <= 1'b0;
      acpi_off_stb <= 1'b0;
    end else begin
      smi_pulse    <= smi_d;
      acpi_on_stb  <= on_d;
      acpi_off_stb <= off_d;
    end
  end

  a_r10_mode_no_smi: assert property (@(posedge clk) disable iff (!rst_n)
    (acpi_on_stb || acpi_off_stb) |-> ((smi_pulse == '0) && !(acpi_on_stb && acpi_off_stb)));
  a_r11_smi_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (|smi_pulse) |-> $past(apm_wr_en && smi_en));
  a_r13_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    ((|smi_pulse) && !$past(bcast)) |-> ($countones(smi_pulse) == 1));
  a_r14_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|smi_pulse) |=> ((smi_pulse == '0) || $past(apm_wr_en)));
endmodule

// File: rtl/smi_feat_negotiator.sv
module smi_feat_negotiator
  import smi_neg_pkg::*;
#(
  parameter feat_mask_t  HOST_MASK     = 64'h7,
  parameter int unsigned NUM_CPUS      = 4,
  parameter logic [7:0]  ACPI_ON_CODE  = 8'hE1,
  parameter logic [7:0]  ACPI_OFF_CODE = 8'h1E,
  localparam int unsigned CPU_W        = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr_en,
  input  logic [BIDX_W-1:0]   req_wr_idx,
  input  logic [7:0]          req_wr_data,
  input  logic                ok_trigger,
  input  logic                apm_wr_en,
  input  logic [7:0]          apm_cmd,
  input  logic [CPU_W-1:0]    apm_cpu_id,
  input  logic                apm_smi_en,
  output logic [FEAT_W-1:0]   req_value,
  output logic                feat_ok,
  output logic [FEAT_W-1:0]   feat_negotiated,
  output logic [NUM_CPUS-1:0] smi_pulse,
  output logic                acpi_on_stb,
  output logic                acpi_off_stb
);
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync[1];

  smi_req_file u_req (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .locked  (feat_ok),
    .wr_en   (req_wr_en),
    .wr_idx  (req_wr_idx),
    .wr_data (req_wr_data),
    .req_q   (req_value)
  );

  smi_feat_lock #(.HOST_MASK(HOST_MASK)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .trigger  (ok_trigger),
    .req      (req_value),
    .feat_ok  (feat_ok),
    .neg_mask (feat_negotiated)
  );

  smi_apm_dispatch #(
    .NUM_CPUS      (NUM_CPUS),
    .ACPI_ON_CODE  (ACPI_ON_CODE),
    .ACPI_OFF_CODE (ACPI_OFF_CODE)
  ) u_apm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .apm_wr_en    (apm_wr_en),
    .apm_cmd      (apm_cmd),
    .cpu_id       (apm_cpu_id),
    .smi_en       (apm_smi_en),
    .bcast        (feat_negotiated[BIT_BCAST]),
    .smi_pulse    (smi_pulse),
    .acpi_on_stb  (acpi_on_stb),
    .acpi_off_stb (acpi_off_stb)
  );

  // R3: the request may only change through a write taken while unlocked
  a_r3_req_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$stable(req_value) |-> $past(req_wr_en && !feat_ok));
endmodule

// File: tb/smi_feat_negotiator_bench.sv
module smi_feat_negotiator_bench;
  localparam logic [63:0] HOST = 64'h7;
  localparam logic [7:0]  ON_C = 8'hE1;
  localparam logic [7:0]  OFF_C = 8'h1E;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_wr_en;
  logic [2:0]  req_wr_idx;
  logic [7:0]  req_wr_data;
  logic        ok_trigger;
  logic        apm_wr_en;
  logic [7:0]  apm_cmd;
  logic [1:0]  apm_cpu_id;
  logic        apm_smi_en;
  logic [63:0] req_value;
  logic        feat_ok;
  logic [63:0] feat_negotiated;
  logic [3:0]  smi_pulse;
  logic        acpi_on_stb;
  logic        acpi_off_stb;

  int tests = 0;
  int fails = 0;

  logic [63:0] m_req, m_neg;
  logic        m_ok, m_on, m_off;
  logic [3:0]  m_smi;

  always #5 clk = ~clk;

  smi_feat_negotiator #(.HOST_MASK(HOST), .NUM_CPUS(4),
    .ACPI_ON_CODE(ON_C), .ACPI_OFF_CODE(OFF_C)) u_smi_feat_negotiator (
    .clk(clk), .rst_n(rst_n), .req_wr_en(req_wr_en), .req_wr_idx(req_wr_idx),
    .req_wr_data(req_wr_data), .ok_trigger(ok_trigger), .apm_wr_en(apm_wr_en),
    .apm_cmd(apm_cmd), .apm_cpu_id(apm_cpu_id), .apm_smi_en(apm_smi_en),
    .req_value(req_value), .feat_ok(feat_ok), .feat_negotiated(feat_negotiated),
    .smi_pulse(smi_pulse), .acpi_on_stb(acpi_on_stb), .acpi_off_stb(acpi_off_stb));

  function automatic logic legal(input logic [63:0] r);
    if ((r & ~HOST) != 64'h0) return 1'b0;
    if ((r[1] || r[2]) && !r[0]) return 1'b0;
    if (r[2] && !r[1]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2/R3 request", req_value, m_req);
    check("R4/R8 features-ok", {63'h0, feat_ok}, {63'h0, m_ok});
    check("R4/R8 negotiated", feat_negotiated, m_neg);
    check("R12/R13 smi", {60'h0, smi_pulse}, {60'h0, m_smi});
    check("R10 acpi strobes", {62'h0, acpi_on_stb, acpi_off_stb}, {62'h0, m_on, m_off});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_wr_en = 0; req_wr_idx = 0; req_wr_data = 0; ok_trigger = 0;
    apm_wr_en = 0; apm_cmd = 0; apm_cpu_id = 0; apm_smi_en = 0;
    m_req = 0; m_neg = 0; m_ok = 0; m_on = 0; m_off = 0; m_smi = 0;
    repeat (3) @(negedge clk);
    compare_all(); // R1 during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all(); // R1 after release
  endtask

  task automatic step(input logic we, input logic [2:0] idx, input logic [7:0] d,
                      input logic trg, input logic aw, input logic [7:0] cmd,
                      input logic [1:0] id, input logic sen);
    logic [63:0] nreq;
    req_wr_en = we; req_wr_idx = idx; req_wr_data = d; ok_trigger = trg;
    apm_wr_en = aw; apm_cmd = cmd; apm_cpu_id = id; apm_smi_en = sen;
    @(posedge clk);
    m_on  = aw && (cmd == ON_C);
    m_off = aw && (cmd == OFF_C);
    m_smi = 4'b0000;
    if (aw && cmd != ON_C && cmd != OFF_C && sen)
      m_smi = m_neg[0] ? 4'b1111 : (4'b0001 << id);
    nreq = m_req;
    if (we && !m_ok) nreq[8*idx +: 8] = d;
    if (trg && !m_ok && legal(m_req)) begin
      m_ok = 1'b1;
      m_neg = m_req;
    end
    m_req = nreq;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();                                        // R1
    // R2: little-endian byte placement
    step(1, 0, 8'h01, 0, 0, 0, 0, 0);
    step(1, 3, 8'h80, 0, 0, 0, 0, 0);
    check("R2 byte order", req_value, 64'h0000_0000_8000_0001);
    // R5: bit 31 outside host mask
    step(0, 0, 0, 1, 0, 0, 0, 0);
    idle();
    check("R5 stray bit rejected", {63'h0, feat_ok}, 64'h0);
    step(1, 3, 8'h00, 0, 0, 0, 0, 0);
    // R6: hotplug without broadcast
    step(1, 0, 8'h02, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    check("R6 hotplug w/o bcast", {63'h0, feat_ok}, 64'h0);
    // R7: hot-unplug without hotplug (bcast set)
    step(1, 0, 8'h05, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    check("R7 unplug w/o plug", {63'h0, feat_ok}, 64'h0);
    check("R7 mask stays clear", feat_negotiated, 64'h0);
    // R13: no broadcast yet, only the issuer
    step(0, 0, 0, 0, 1, 8'h10, 2'd2, 1);
    check("R13 single target", {60'h0, smi_pulse}, 64'h4);
    // R14: pulse gone next cycle
    idle();
    check("R14 one cycle", {60'h0, smi_pulse}, 64'h0);
    // R4/R9: retry with legal request; same-cycle write must not be seen
    step(1, 0, 8'h07, 0, 0, 0, 0, 0);
    step(1, 0, 8'h3F, 1, 0, 0, 0, 0);
    check("R4/R9 accepted", {63'h0, feat_ok}, 64'h1);
    check("R4 locked value", feat_negotiated, 64'h7);
    check("R4 write same cycle landed", req_value, 64'h3F);
    // R3: writes after lock ignored
    step(1, 1, 8'hAA, 0, 0, 0, 0, 0);
    check("R3 write ignored", req_value, 64'h3F);
    // R8: further triggers do nothing
    step(0, 0, 0, 1, 0, 0, 0, 0);
    check("R8 mask held", feat_negotiated, 64'h7);
    // R10: mode codes give strobes and no SMI even with enable high
    step(0, 0, 0, 0, 1, ON_C, 1, 1);
    check("R10 on strobe", {62'h0, acpi_on_stb, acpi_off_stb}, 64'h2);
    check("R10 no smi on", {60'h0, smi_pulse}, 64'h0);
    step(0, 0, 0, 0, 1, OFF_C, 1, 1);
    check("R10 off strobe", {62'h0, acpi_on_stb, acpi_off_stb}, 64'h1);
    // R11: enable low blocks SMI
    step(0, 0, 0, 0, 1, 8'h42, 1, 0);
    check("R11 disabled", {60'h0, smi_pulse}, 64'h0);
    // R12: broadcast to all
    step(0, 0, 0, 0, 1, 8'h42, 1, 1);
    check("R12 broadcast", {60'h0, smi_pulse}, 64'hF);
    idle();
    check("R14 broadcast one cycle", {60'h0, smi_pulse}, 64'h0);

    // Random phase against the model, with occasional resets
    for (int round = 0; round < 6; round++) begin
      do_reset();
      for (int n = 0; n < 600; n++) begin
        logic we, trg, aw, sen;
        logic [2:0] idx;
        logic [7:0] d, cmd;
        logic [1:0] id;
        int sel;
        we  = ($urandom_range(0, 2) == 0);
        idx = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
        d   = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'($urandom_range(0, 7));
        if (idx != 0 && $urandom_range(0, 1) == 0) d = 8'h00;
        trg = ($urandom_range(0, 7) == 0);
        aw  = ($urandom_range(0, 3) == 0);
        sel = $urandom_range(0, 5);
        cmd = (sel == 0) ? ON_C : (sel == 1) ? OFF_C : 8'($urandom);
        id  = 2'($urandom_range(0, 3));
        sen = ($urandom_range(0, 3) != 0);
        step(we, idx, d, trg, aw, cmd, id, sen);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule